// File: doc/BRIEF.md
# Quarter-Wave Coarse Sine/Cosine Lookup

This block turns the integer part of a synthesizer phase word into a coarse sine sample and a coarse cosine sample. It keeps only one quarter of a sine period in a table with two read ports, and both outputs are served from that one table. The two top phase bits give the quadrant. The rest of the phase word is the table address, and on each port it is bit-inverted or passed through depending on the quadrant. The quadrant also decides whether each output is sign-inverted.

Every table entry is the sine of the centre of its phase step, so the sampled angle sits half a phase step above the step's start. With this offset, bitwise address inversion mirrors the table exactly about pi/2, and no two quadrant boundaries read the same entry. Each output code c stands for the amplitude (c + 0.5) LSB. Negating an output is therefore an exact bitwise inversion, with no adder and no rounding error. Table contents are computed from a quarter-wave formula when the design is elaborated. Both outputs are registered, so there is one clock of latency.

Top module: `quarter_sincos_lut`

## Requirements
- R1: While rst_n is low, sin_o and cos_o are zero.
- R2: sin_o and cos_o hold the samples for the phase_i value sampled at the previous rising clock edge (one cycle of latency), and a new phase can be given every cycle.
- R3: For phase p, the code c on sin_o (two's complement) satisfies |(c + 0.5) - 2^(AMP_W-1) * sin(2*pi*(p+0.5)/2^PH_W)| <= 1.
- R4: For phase p, the code c on cos_o satisfies the same bound against 2^(AMP_W-1) * cos(2*pi*(p+0.5)/2^PH_W).
- R5: The quadrant is phase_i[PH_W-1:PH_W-2]. The sin_o sign bit is 1 exactly in quadrants 2 and 3, and the cos_o sign bit is 1 exactly in quadrants 1 and 2.
- R6: The output for phase p + 2^(PH_W-1) (modulo 2^PH_W) is the bitwise inverse of the output for phase p, on both sin_o and cos_o.
- R7: In quadrant 0, sin_o for phase p equals sin_o for phase 2^(PH_W-1)-1-p. For every phase p, cos_o equals sin_o for phase p + 2^(PH_W-2) (modulo 2^PH_W).
- R8: At the quadrant boundaries no two angles alias. sin_o at phase 0 is the smallest positive code, and it differs from sin_o at phase 2^(PH_W-2). sin_o at phase 2^PH_W-1 is its bitwise inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| phase_i | input | PH_W | Integer part of the phase word |
| sin_o | output | AMP_W | Registered coarse sine, two's complement, code c means c+0.5 LSB |
| cos_o | output | AMP_W | Registered coarse cosine, same coding |

## Verification
A wrong address-flip or negate decision corrupts a whole quadrant. It shows on the very next clock as a sign bit that disagrees with the quadrant, or as a value breaking the half-period inversion rule. A bad table entry only shows when its address is read, so every phase is swept and each output is compared with an independently computed sine and cosine one cycle after it is applied. The mirror and boundary checks catch a missing half-step offset, because without it the two samples on either side of pi/2 would not match.

// File: rtl/qsl_pkg.sv
package qsl_pkg;

  localparam real HALF_PI = 1.5707963267948966;

  // Odd power series for sine, good to well below one LSB on [0, pi/2]
  function automatic real series_sin(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 13; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Stored code for quarter-table entry k: sine at the centre of step k,
  // reduced by half an LSB so that bitwise inversion negates exactly.
  function automatic longint quarter_code(input int k, input int aw, input int w);
    real    ang;
    real    full;
    real    v;
    longint c;
    longint cmax;
    ang  = (real'(k) + 0.5) * HALF_PI / (2.0 ** aw);
    full = 2.0 ** (w - 1);
    v    = series_sin(ang) * full - 0.5;
    c    = longint'($rtoi(v + 0.5));
    cmax = (longint'(1) <<< (w - 1)) - 1;
    if (c > cmax) c = cmax;
    if (c < 0) c = 0;
    return c;
  endfunction

endpackage

// File: rtl/qsl_addr_ctl.sv
module qsl_addr_ctl #(
  parameter int PH_W = 10
) (
  input  logic [PH_W-1:0] phase,
  output logic [PH_W-3:0] sin_addr,
  output logic [PH_W-3:0] cos_addr,
  output logic            sin_neg,
  output logic            cos_neg
);
  localparam int ADDR_W = PH_W - 2;

  logic [1:0]        quad;
  logic [ADDR_W-1:0] offs;
  logic              sin_flip;
  logic              cos_flip;

  always_comb begin
    quad     = phase[PH_W-1:PH_W-2];
    offs     = phase[ADDR_W-1:0];
    // sine reads backwards in odd quadrants; cosine is sine one quadrant on
    sin_flip = quad[0];
    cos_flip = ~quad[0];
    sin_addr = offs ^ {ADDR_W{sin_flip}};
    cos_addr = offs ^ {ADDR_W{cos_flip}};
    sin_neg  = quad[1];
    cos_neg  = quad[1] ^ quad[0];
  end
endmodule

// File: rtl/qsl_quarter_rom.sv
module qsl_quarter_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 22
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [AMP_W-1:0]  data_a,
  output logic [AMP_W-1:0]  data_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [AMP_W-1:0] qtab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [AMP_W-1:0] ENTRY = AMP_W'(qsl_pkg::quarter_code(i, ADDR_W, AMP_W));
    assign qtab[i] = ENTRY;
  end

  assign data_a = qtab[addr_a];
  assign data_b = qtab[addr_b];
endmodule

// File: rtl/quarter_sincos_lut.sv
module quarter_sincos_lut #(
  parameter int PH_W  = 10,
  parameter int AMP_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  phase_i,
  output logic [AMP_W-1:0] sin_o,
  output logic [AMP_W-1:0] cos_o
);
  localparam int ADDR_W = PH_W - 2;

  logic [ADDR_W-1:0] sin_addr;
  logic [ADDR_W-1:0] cos_addr;
  logic              sin_neg;
  logic              cos_neg;
  logic [AMP_W-1:0]  sin_mag;
  logic [AMP_W-1:0]  cos_mag;
  logic [AMP_W-1:0]  sin_d;
  logic [AMP_W-1:0]  cos_d;
  logic [AMP_W-1:0]  sin_q;
  logic [AMP_W-1:0]  cos_q;

  qsl_addr_ctl #(.PH_W(PH_W)) u_addr (
    .phase    (phase_i),
    .sin_addr (sin_addr),
    .cos_addr (cos_addr),
    .sin_neg  (sin_neg),
    .cos_neg  (cos_neg)
  );

  qsl_quarter_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .addr_a (sin_addr),
    .addr_b (cos_addr),
    .data_a (sin_mag),
    .data_b (cos_mag)
  );

  // next state: negation is a plain inversion thanks to the half-LSB coding
  always_comb begin
    sin_d = sin_mag ^ {AMP_W{sin_neg}};
    cos_d = cos_mag ^ {AMP_W{cos_neg}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= sin_d;
      cos_q <= cos_d;
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;
endmodule

// File: rtl/qsl_checker.sv
module qsl_checker #(
  parameter int PH_W  = 10,
  parameter int AMP_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PH_W-1:0]  phase_i,
  input logic [AMP_W-1:0] sin_o,
  input logic [AMP_W-1:0] cos_o
);
  localparam logic [PH_W-1:0] HALF = PH_W'(1) << (PH_W - 1);

  logic [1:0] live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 2'b00;
    else        live <= {live[0], 1'b1};
  end

  // R1
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sin_o == '0 && cos_o == '0));

  // R5
  p_sin_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live[0] |-> sin_o[AMP_W-1] == $past(phase_i[PH_W-1]));

  // R5
  p_cos_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live[0] |-> cos_o[AMP_W-1] == ($past(phase_i[PH_W-1]) ^ $past(phase_i[PH_W-2])));

  // R6
  p_half_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live[1] && ($past(phase_i, 1) == ($past(phase_i, 2) ^ HALF)))
      |-> (sin_o == ~$past(sin_o) && cos_o == ~$past(cos_o)));

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live[0] && $stable(phase_i)) |=> ($stable(sin_o) && $stable(cos_o)));
endmodule

bind quarter_sincos_lut qsl_checker #(.PH_W(PH_W), .AMP_W(AMP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase_i (phase_i),
  .sin_o   (sin_o),
  .cos_o   (cos_o)
);

// File: tb/quarter_sincos_lut_test.sv
module quarter_sincos_lut_test;
  localparam int  PH_W  = 10;
  localparam int  AMP_W = 22;
  localparam int  NPH   = 1 << PH_W;
  localparam int  QTR   = NPH / 4;
  localparam int  HLF   = NPH / 2;
  localparam real TWO_PI = 6.283185307179586;

  logic             clk;
  logic             rst_n;
  logic [PH_W-1:0]  phase_i;
  logic [AMP_W-1:0] sin_o;
  logic [AMP_W-1:0] cos_o;

  int checks;
  int fails;
  bit done;

  quarter_sincos_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) uut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .sin_o(sin_o), .cos_o(cos_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge loads, sample a little later
  task automatic apply(input int p, output logic [AMP_W-1:0] s, output logic [AMP_W-1:0] c);
    @(negedge clk);
    phase_i = PH_W'(p);
    @(posedge clk);
    #1;
    s = sin_o;
    c = cos_o;
  endtask

  function automatic bit near(input logic [AMP_W-1:0] code, input real amp);
    real err;
    err = real'($signed(code)) + 0.5 - amp;
    return (err <= 1.0) && (err >= -1.0);
  endfunction

  function automatic longint ideal(input int p, input bit cosine);
    real ang;
    ang = TWO_PI * (real'(p) + 0.5) / real'(NPH);
    return longint'($rtoi((cosine ? $cos(ang) : $sin(ang)) * (2.0 ** (AMP_W - 1))));
  endfunction

  task automatic test_reset();
    rst_n   = 1'b0;
    phase_i = PH_W'(QTR + 5);
    repeat (3) @(posedge clk);
    #1;
    check(sin_o == '0, "R1 sin in reset", longint'(sin_o), 0);
    check(cos_o == '0, "R1 cos in reset", longint'(cos_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_sweep();
    logic [AMP_W-1:0] s;
    logic [AMP_W-1:0] c;
    for (int p = 0; p < NPH; p++) begin
      apply(p, s, c);
      check(near(s, real'(ideal(p, 1'b0))), "R3 sin accuracy", longint'($signed(s)), ideal(p, 1'b0));
      check(near(c, real'(ideal(p, 1'b1))), "R4 cos accuracy", longint'($signed(c)), ideal(p, 1'b1));
      check(s[AMP_W-1] == (p >= HLF), "R5 sin sign", longint'(s[AMP_W-1]), longint'(p >= HLF));
      check(c[AMP_W-1] == (p >= QTR && p < 3 * QTR), "R5 cos sign",
            longint'(c[AMP_W-1]), longint'(p >= QTR && p < 3 * QTR));
    end
  endtask

  task automatic test_latency();
    int seq [6] = '{3, 700, 129, 512, 1000, 255};
    logic [AMP_W-1:0] sref [6];
    logic [AMP_W-1:0] cref [6];
    logic [AMP_W-1:0] dummy;
    for (int i = 0; i < 6; i++) apply(seq[i], sref[i], cref[i]);
    // back to back, each phase held exactly one cycle
    @(negedge clk);
    phase_i = PH_W'(seq[0]);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      check(sin_o == sref[i], "R2 back-to-back sin", longint'(sin_o), longint'(sref[i]));
      check(cos_o == cref[i], "R2 back-to-back cos", longint'(cos_o), longint'(cref[i]));
      @(negedge clk);
      if (i < 5) phase_i = PH_W'(seq[i + 1]);
    end
    dummy = sin_o;
    check(dummy == sref[5], "R2 output holds", longint'(dummy), longint'(sref[5]));
  endtask

  task automatic test_half_invert();
    int pts [5] = '{0, 77, 255, 300, 511};
    logic [AMP_W-1:0] s0, c0, s1, c1;
    foreach (pts[i]) begin
      apply(pts[i], s0, c0);
      apply(pts[i] + HLF, s1, c1);
      check(s1 == ~s0, "R6 sin inversion", longint'(s1), longint'(~s0));
      check(c1 == ~c0, "R6 cos inversion", longint'(c1), longint'(~c0));
    end
  endtask

  task automatic test_mirror();
    int pts [5] = '{0, 1, 100, 254, 255};
    logic [AMP_W-1:0] s0, c0, s1, c1;
    foreach (pts[i]) begin
      apply(pts[i], s0, c0);
      apply(HLF - 1 - pts[i], s1, c1);
      check(s1 == s0, "R7 quarter mirror", longint'(s1), longint'(s0));
      apply((pts[i] * 3 + 200) % NPH, s0, c0);
      apply(((pts[i] * 3 + 200) + QTR) % NPH, s1, c1);
      check(c0 == s1, "R7 cos is shifted sin", longint'(c0), longint'(s1));
    end
  endtask

  task automatic test_boundaries();
    logic [AMP_W-1:0] s0, c0, sq, cq, se, ce, sx, cx;
    apply(0, s0, c0);
    apply(QTR, sq, cq);
    apply(NPH - 1, se, ce);
    apply(1, sx, cx);
    check(!s0[AMP_W-1] && s0 != '0, "R8 sin at zero positive", longint'($signed(s0)), 1);
    check(s0 < sx, "R8 sin at zero smallest", longint'(s0), longint'(sx));
    check(s0 != sq, "R8 no alias at quarter", longint'(s0), longint'(sq));
    check(se == ~s0, "R8 last phase inverse", longint'(se), longint'(~s0));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    phase_i = '0;
    test_reset();
    test_sweep();
    test_latency();
    test_half_invert();
    test_mirror();
    test_boundaries();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule